// File: doc/BRIEF.md
# Flash Command Interface for One Bank

This block is the command front end of a single flash bank. The host runs bus write cycles on two active-low strobes, one for write enable and one for bank select. A cycle counts when both strobes have been low together, and the block captures the address and data from the last clock in which both were still low. The block decodes one-cycle commands and two-cycle sequences, and sets what a read returns: array words, identifier codes or the status register. It starts erase, word write and lock-bit operations on a timer model, and it supports suspending and resuming them.

The array is a small register model of `NBLK` blocks of `WPB` words each. An erase takes `ERASE_CYC` clocks and every other operation takes `WRITE_CYC` clocks. The input `lock_grant` is the permission the surrounding system gives for changes to locked blocks and for the permanent lock. The input `vpp_low` reports that the programming supply is too low. Reads are combinational from `addr`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the bank is in array read mode, every word reads FFFFh and the status register reads 0080h.
- R2: The low byte of each command selects the read mode. FFh selects array data and 70h selects the status register. 90h selects identifier codes, decoded by the low two word-address bits: 0 gives `MFR_ID`, 1 gives `DEV_ID`, 2 gives the lock bit of the addressed block and 3 gives the permanent lock bit. 50h clears status bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R3: Erase is 20h followed by D0h. It sets every word of the block addressed in the second cycle to FFFFh once `ERASE_CYC` clocks have passed, and reads then show the status register.
- R4: Word write is a setup cycle of 40h or 10h, followed by a cycle that carries the word address and the 16-bit data. The word is stored after `WRITE_CYC` clocks.
- R5: While an operation runs, status bit 7 is 0 and every read returns the status register. Every command except B0h is ignored.
- R6: B0h during a word write suspends it: bit 7 goes to 1 and bit 2 is set. While suspended, only the read-mode commands, 50h and D0h (resume) have any effect.
- R7: B0h during an erase suspends it: bit 7 goes to 1 and bit 6 is set. Reads and word writes to other blocks work while it is suspended. A word write to the suspended block sets bit 4 and does not run. D0h resumes the erase when no write is running.
- R8: After 60h, a second cycle of 01h sets the addressed block's lock bit, refused if the permanent lock is set. F1h sets the permanent lock, refused unless `lock_grant` is high. D0h clears all block lock bits, refused if the permanent lock is set or `lock_grant` is low. A refused 01h or F1h sets bits 4 and 1. A refused D0h sets bits 5 and 1.
- R9: An erase or word write to a locked block runs only when `lock_grant` is high and the permanent lock is clear. Otherwise bit 1 is set together with bit 5 (erase) or bit 4 (write), and the array is unchanged.
- R10: With `vpp_low` high at launch, an operation sets bit 3 and its error bit (bit 5 for erase and clear-locks, bit 4 otherwise), and the array is unchanged.
- R11: An unexpected second-cycle code after 20h or 60h sets bits 5 and 4 and returns to array read mode. The error bits then hold until 50h.
- R12: Write data and address are taken from the last clock in which both strobes were low. Values driven after the first strobe rises are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_n | input | 1 | Write-enable strobe, active low |
| sel_n | input | 1 | Bank-select strobe, active low |
| addr | input | clog2(NBLK*WPB) (4) | Word address for bus cycles and reads |
| din | input | 16 | Command or write data |
| lock_grant | input | 1 | System permission for locked-block and permanent-lock changes |
| vpp_low | input | 1 | Programming supply is below its working level |
| dout | output | 16 | Read data: array word, identifier code or status |

## Verification
The bench issues commands in the middle of suspended operations. An erase command sent during a suspended write must be ignored. A design that accepted it would take the following 70h as a bad second cycle, drop to array mode, and show FFFFh where the status should be. A word write aimed at the block whose erase is suspended must be refused. A design that let it through would store the word and then lose it when the erase resumes. The lock matrix is run with the permanent lock clear and then set. A design that left the permanent lock out of its checks would clear or change protected blocks that should keep their contents. A FFh sent during busy and data that changes right after the first strobe rises cover ignored commands and the capture point.

// File: rtl/fcui_pkg.sv
// Shared types and codes for the flash command interface.
// Assumes commands sit in the low byte of the data bus.
package fcui_pkg;
    typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} rd_mode_t;
    typedef enum logic [2:0] {OP_ERASE, OP_WRITE, OP_LOCK_SET, OP_PERM_SET, OP_LOCK_CLR} op_kind_t;

    localparam logic [7:0] C_ARRAY   = 8'hFF;
    localparam logic [7:0] C_IDENT   = 8'h90;
    localparam logic [7:0] C_STATUS  = 8'h70;
    localparam logic [7:0] C_CLEAR   = 8'h50;
    localparam logic [7:0] C_ERASE   = 8'h20;
    localparam logic [7:0] C_WRITE_A = 8'h40;
    localparam logic [7:0] C_WRITE_B = 8'h10;
    localparam logic [7:0] C_SUSPEND = 8'hB0;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_LOCK    = 8'h60;
    localparam logic [7:0] C_LK_BLK  = 8'h01;
    localparam logic [7:0] C_LK_PERM = 8'hF1;
endpackage

// File: rtl/fcui_wcap.sv
// Bus write capture: a cycle is one stretch in which both strobes are low.
// The address and data of the last clock in that stretch are kept, and one
// valid pulse is raised in the clock where either strobe is first seen high.
// Assumes the strobes are already synchronous to clk.
module fcui_wcap #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic          sel_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          cyc_valid,
    output logic [AW-1:0] cyc_addr,
    output logic [DW-1:0] cyc_data
);
    logic          act, act_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;

    assign act = !wr_n && !sel_n;

    // Keep the bus values of every clock in which both strobes are low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            a_q   <= '0;
            d_q   <= '0;
        end else begin
            act_q <= act;
            if (act) begin
                a_q <= addr;
                d_q <= din;
            end
        end
    end

    assign cyc_valid = act_q && !act;
    assign cyc_addr  = a_q;
    assign cyc_data  = d_q;
endmodule

// File: rtl/fcui_decode.sv
// Command decoder: follows the two-cycle sequences and holds the read mode.
// It issues single-clock requests (start, suspend, resume, clear, sequence
// error) to the engine. Assumes the engine judges every permission itself.
module fcui_decode
    import fcui_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cyc_valid,
    input  logic [7:0] cyc_code,
    input  logic     busy,
    input  logic     ers_susp,
    input  logic     wr_susp,
    output rd_mode_t mode,
    output logic     start,
    output op_kind_t start_kind,
    output logic     suspend,
    output logic     resume,
    output logic     seq_err,
    output logic     clr_err
);
    typedef enum logic [1:0] {DS_IDLE, DS_ERASE, DS_WRITE, DS_LOCK} dstate_t;
    dstate_t  state, nstate;
    rd_mode_t nmode;
    logic     susp_any;

    assign susp_any = ers_susp || wr_susp;

    // Next state, next read mode and the request pulses for this cycle.
    always_comb begin
        nstate     = state;
        nmode      = mode;
        start      = 1'b0;
        start_kind = OP_WRITE;
        suspend    = 1'b0;
        resume     = 1'b0;
        seq_err    = 1'b0;
        clr_err    = 1'b0;
        if (cyc_valid) begin
            case (state)
                DS_IDLE: begin
                    if (busy) begin
                        if (cyc_code == C_SUSPEND) begin
                            suspend = 1'b1;
                            nmode   = RD_STATUS;
                        end
                    end else begin
                        case (cyc_code)
                            C_ARRAY:  nmode = RD_ARRAY;
                            C_IDENT:  nmode = RD_IDENT;
                            C_STATUS: nmode = RD_STATUS;
                            C_CLEAR:  clr_err = 1'b1;
                            C_ERASE: if (!susp_any) begin
                                nstate = DS_ERASE;
                                nmode  = RD_STATUS;
                            end
                            C_WRITE_A, C_WRITE_B: if (!wr_susp) begin
                                nstate = DS_WRITE;
                                nmode  = RD_STATUS;
                            end
                            C_LOCK: if (!susp_any) begin
                                nstate = DS_LOCK;
                                nmode  = RD_STATUS;
                            end
                            C_CONFIRM: if (susp_any) begin
                                resume = 1'b1;
                                nmode  = RD_STATUS;
                            end
                            default: ;
                        endcase
                    end
                end
                DS_ERASE: begin
                    nstate = DS_IDLE;
                    if (cyc_code == C_CONFIRM) begin
                        start      = 1'b1;
                        start_kind = OP_ERASE;
                    end else begin
                        seq_err = 1'b1;
                        nmode   = RD_ARRAY;
                    end
                end
                DS_WRITE: begin
                    nstate     = DS_IDLE;
                    start      = 1'b1;
                    start_kind = OP_WRITE;
                end
                default: begin
                    nstate = DS_IDLE;
                    case (cyc_code)
                        C_LK_BLK:  begin start = 1'b1; start_kind = OP_LOCK_SET;  end
                        C_LK_PERM: begin start = 1'b1; start_kind = OP_PERM_SET;  end
                        C_CONFIRM: begin start = 1'b1; start_kind = OP_LOCK_CLR;  end
                        default:   begin seq_err = 1'b1; nmode = RD_ARRAY; end
                    endcase
                end
            endcase
        end
    end

    // Register the sequence state and the read mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DS_IDLE;
            mode  <= RD_ARRAY;
        end else begin
            state <= nstate;
            mode  <= nmode;
        end
    end
endmodule

// File: rtl/fcui_engine.sv
// Operation engine: permission checks at launch, the busy timer, suspend and
// resume, the array and lock model, and the status register.
// Assumes the decoder never asks for start and resume in the same clock.
module fcui_engine
    import fcui_pkg::*;
#(
    parameter int NBLK      = 4,
    parameter int WPB       = 4,
    parameter int ERASE_CYC = 40,
    parameter int WRITE_CYC = 12,
    localparam int AW = $clog2(NBLK * WPB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_kind_t      start_kind,
    input  logic [AW-1:0] start_addr,
    input  logic [15:0]   start_data,
    input  logic          suspend,
    input  logic          resume,
    input  logic          seq_err,
    input  logic          clr_err,
    input  logic          lock_grant,
    input  logic          vpp_low,
    input  logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          ers_susp,
    output logic          wr_susp,
    output logic [7:0]    sts,
    output logic [15:0]   rd_word,
    output logic          rd_lock,
    output logic          perm_lock
);
    localparam int NWORD = NBLK * WPB;
    localparam int OW    = $clog2(WPB);
    localparam int BW    = AW - OW;
    localparam int MAXC  = (ERASE_CYC > WRITE_CYC) ? ERASE_CYC : WRITE_CYC;
    localparam int CW    = $clog2(MAXC + 1);

    logic [15:0]     mem [NWORD];
    logic [NBLK-1:0] blk_lock;
    logic            op_run;
    op_kind_t        op_kind;
    logic [AW-1:0]   op_addr;
    logic [15:0]     op_data;
    logic [CW-1:0]   op_cnt, sv_cnt;
    logic [BW-1:0]   sv_blk, s_blk, op_blk;
    logic            eerr, werr, lowv, lkerr;
    logic            go, rej_e, rej_w, rej_v, rej_l, lock_ok;

    assign s_blk   = start_addr[AW-1:OW];
    assign op_blk  = op_addr[AW-1:OW];
    assign lock_ok = !blk_lock[s_blk] || (lock_grant && !perm_lock);

    // Decide whether a start request runs or which error bits it raises.
    always_comb begin
        go = 1'b0; rej_e = 1'b0; rej_w = 1'b0; rej_v = 1'b0; rej_l = 1'b0;
        if (start) begin
            if (vpp_low) begin
                rej_v = 1'b1;
                if (start_kind == OP_ERASE || start_kind == OP_LOCK_CLR) rej_e = 1'b1;
                else rej_w = 1'b1;
            end else begin
                case (start_kind)
                    OP_WRITE:
                        if (ers_susp && s_blk == sv_blk) rej_w = 1'b1;
                        else if (!lock_ok) begin rej_w = 1'b1; rej_l = 1'b1; end
                        else go = 1'b1;
                    OP_ERASE:
                        if (!lock_ok) begin rej_e = 1'b1; rej_l = 1'b1; end
                        else go = 1'b1;
                    OP_LOCK_SET:
                        if (perm_lock) begin rej_w = 1'b1; rej_l = 1'b1; end
                        else go = 1'b1;
                    OP_PERM_SET:
                        if (!lock_grant) begin rej_w = 1'b1; rej_l = 1'b1; end
                        else go = 1'b1;
                    default:
                        if (perm_lock || !lock_grant) begin rej_e = 1'b1; rej_l = 1'b1; end
                        else go = 1'b1;
                endcase
            end
        end
    end

    // Error bits: set by refusals and sequence errors, cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {eerr, werr, lowv, lkerr} <= '0;
        end else begin
            if (clr_err) {eerr, werr, lowv, lkerr} <= '0;
            if (seq_err || rej_e) eerr <= 1'b1;
            if (seq_err || rej_w) werr <= 1'b1;
            if (rej_v) lowv <= 1'b1;
            if (rej_l) lkerr <= 1'b1;
        end
    end

    // Timer, suspend and resume, and the effect applied when an operation ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_run    <= 1'b0;
            op_kind   <= OP_WRITE;
            op_addr   <= '0;
            op_data   <= '0;
            op_cnt    <= '0;
            sv_cnt    <= '0;
            sv_blk    <= '0;
            ers_susp  <= 1'b0;
            wr_susp   <= 1'b0;
            blk_lock  <= '0;
            perm_lock <= 1'b0;
            for (int i = 0; i < NWORD; i++) mem[i] <= 16'hFFFF;
        end else if (go) begin
            op_run  <= 1'b1;
            op_kind <= start_kind;
            op_addr <= start_addr;
            op_data <= start_data;
            op_cnt  <= (start_kind == OP_ERASE) ? CW'(ERASE_CYC) : CW'(WRITE_CYC);
        end else if (resume && wr_susp) begin
            op_run  <= 1'b1;
            wr_susp <= 1'b0;
        end else if (resume && ers_susp && !op_run) begin
            op_run   <= 1'b1;
            op_kind  <= OP_ERASE;
            op_addr  <= {sv_blk, {OW{1'b0}}};
            op_cnt   <= sv_cnt;
            ers_susp <= 1'b0;
        end else if (op_run && suspend && op_kind == OP_ERASE) begin
            op_run   <= 1'b0;
            sv_blk   <= op_blk;
            sv_cnt   <= op_cnt;
            ers_susp <= 1'b1;
        end else if (op_run && suspend && op_kind == OP_WRITE && !ers_susp) begin
            op_run  <= 1'b0;
            wr_susp <= 1'b1;
        end else if (op_run) begin
            if (op_cnt == CW'(1)) begin
                op_run <= 1'b0;
                case (op_kind)
                    OP_ERASE:    for (int w = 0; w < WPB; w++) mem[{op_blk, OW'(w)}] <= 16'hFFFF;
                    OP_WRITE:    mem[op_addr] <= op_data;
                    OP_LOCK_SET: blk_lock[op_blk] <= 1'b1;
                    OP_PERM_SET: perm_lock <= 1'b1;
                    default:     blk_lock <= '0;
                endcase
            end else begin
                op_cnt <= op_cnt - CW'(1);
            end
        end
    end

    assign busy    = op_run;
    assign sts     = {!op_run, ers_susp, eerr, werr, lowv, wr_susp, lkerr, 1'b0};
    assign rd_word = mem[rd_addr];
    assign rd_lock = blk_lock[rd_addr[AW-1:OW]];
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command interface for one bank: write capture, decoder,
// engine and the read multiplexer. Assumes WPB >= 4, so that the identifier
// offsets fit within one block.
module flash_cmd_ctrl
    import fcui_pkg::*;
#(
    parameter int          NBLK      = 4,
    parameter int          WPB       = 4,
    parameter int          ERASE_CYC = 40,
    parameter int          WRITE_CYC = 12,
    parameter logic [15:0] MFR_ID    = 16'h0051,
    parameter logic [15:0] DEV_ID    = 16'h00A7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_n,
    input  logic                          sel_n,
    input  logic [$clog2(NBLK*WPB)-1:0]   addr,
    input  logic [15:0]                   din,
    input  logic                          lock_grant,
    input  logic                          vpp_low,
    output logic [15:0]                   dout
);
    localparam int AW = $clog2(NBLK * WPB);

    logic          cyc_valid, start, suspend, resume, seq_err, clr_err;
    logic [AW-1:0] cyc_addr;
    logic [15:0]   cyc_data, rd_word;
    logic          busy, ers_susp, wr_susp, rd_lock, perm_lock;
    logic [7:0]    sts;
    op_kind_t      start_kind;
    rd_mode_t      mode;

    fcui_wcap #(.AW(AW), .DW(16)) u_cap (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_n(sel_n),
        .addr(addr), .din(din),
        .cyc_valid(cyc_valid), .cyc_addr(cyc_addr), .cyc_data(cyc_data)
    );

    fcui_decode u_dec (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_code(cyc_data[7:0]),
        .busy(busy), .ers_susp(ers_susp), .wr_susp(wr_susp),
        .mode(mode), .start(start), .start_kind(start_kind), .suspend(suspend),
        .resume(resume), .seq_err(seq_err), .clr_err(clr_err)
    );

    fcui_engine #(.NBLK(NBLK), .WPB(WPB), .ERASE_CYC(ERASE_CYC), .WRITE_CYC(WRITE_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .start_kind(start_kind),
        .start_addr(cyc_addr), .start_data(cyc_data), .suspend(suspend),
        .resume(resume), .seq_err(seq_err), .clr_err(clr_err),
        .lock_grant(lock_grant), .vpp_low(vpp_low), .rd_addr(addr),
        .busy(busy), .ers_susp(ers_susp), .wr_susp(wr_susp), .sts(sts),
        .rd_word(rd_word), .rd_lock(rd_lock), .perm_lock(perm_lock)
    );

    // Choose the read data: status while busy or in status mode, else the mode's source.
    always_comb begin
        if (busy || mode == RD_STATUS) begin
            dout = {8'h00, sts};
        end else if (mode == RD_IDENT) begin
            case (addr[1:0])
                2'd0:    dout = MFR_ID;
                2'd1:    dout = DEV_ID;
                2'd2:    dout = {15'd0, rd_lock};
                default: dout = {15'd0, perm_lock};
            endcase
        end else begin
            dout = rd_word;
        end
    end
endmodule

// File: rtl/fcui_chk.sv
// Checker for the flash command interface, bound to the top module.
module fcui_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        ers_susp,
    input logic        wr_susp,
    input logic        cyc_valid,
    input logic [7:0]  cyc_code,
    input logic [7:0]  sts,
    input logic [15:0] dout
);
    // R5: while busy the read port carries a not-ready status word.
    p_busy_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dout[7] == 1'b0 && dout[15:8] == 8'h00));

    // R11: the erase error bit holds until a clear command arrives.
    p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[5] && !(cyc_valid && cyc_code == 8'h50)) |=> sts[5]);

    // R6: a write suspension only begins from a running operation.
    p_wsusp_from_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_susp) |-> $past(busy));

    // R7: an erase suspension only begins from a running operation.
    p_esusp_from_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ers_susp) |-> $past(busy));

    // R7: both suspend flags are never set together.
    p_susp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ers_susp && wr_susp));

    // R3: an operation starts only from a bus write cycle.
    p_launch_by_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cyc_valid));
endmodule

bind flash_cmd_ctrl fcui_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ers_susp(ers_susp), .wr_susp(wr_susp),
    .cyc_valid(cyc_valid), .cyc_code(cyc_data[7:0]), .sts(sts), .dout(dout)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n, wr_n, sel_n, lock_grant, vpp_low;
    logic [AW-1:0] addr;
    logic [15:0]   din, dout;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_n(sel_n), .addr(addr),
        .din(din), .lock_grant(lock_grant), .vpp_low(vpp_low), .dout(dout)
    );

    typedef struct {
        logic [15:0] exp;
        logic [15:0] msk;
        string       tag;
    } item_t;

    item_t sbq[$];
    item_t mon_it;
    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;

    // Monitor: pops an expected item and compares it just after the next edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                mon_it = sbq.pop_front();
                total++;
                if ((dout & mon_it.msk) !== (mon_it.exp & mon_it.msk)) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", mon_it.tag, dout & mon_it.msk,
                             mon_it.exp & mon_it.msk);
                end
            end
        end
    end

    // Driver: queues the expected read value at address a.
    task automatic chk(input logic [AW-1:0] a, input logic [15:0] e, input string tag,
                       input logic [15:0] m = 16'hFFFF);
        @(negedge clk);
        addr = a;
        sbq.push_back('{e, m, tag});
        @(posedge clk);
        #2;
    endtask

    // One bus write cycle. The bus is scrambled once the first strobe rises.
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input bit sel_first = 1'b0);
        @(negedge clk);
        addr = a; din = d; wr_n = 1'b0; sel_n = 1'b0;
        @(negedge clk);
        if (sel_first) sel_n = 1'b1; else wr_n = 1'b1;
        addr = ~a; din = ~d;
        @(negedge clk);
        wr_n = 1'b1; sel_n = 1'b1;
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (!dout[7] && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) begin
            total++; bad++;
            $display("FAIL %s: actual=busy expected=ready", tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R5 watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_n = 1'b1; sel_n = 1'b1; addr = '0; din = '0;
        lock_grant = 1'b0; vpp_low = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk(0, 16'hFFFF, "R1 array word after reset");
        chk(9, 16'hFFFF, "R1 array word after reset");
        wr(0, 16'h0070);
        chk(0, 16'h0080, "R1 status after reset");

        // R4 and R5: a word write, then a command sent while busy
        wr(5, 16'h0040); wr(5, 16'h1234);
        chk(0, 16'h0000, "R5 busy shows not ready", 16'h0080);
        wr(0, 16'h00FF);
        chk(0, 16'h0000, "R5 command ignored while busy", 16'h0080);
        wait_ready("R4 write completes");
        chk(0, 16'h0080, "R4 status after write");
        wr(0, 16'h00FF);
        chk(5, 16'h1234, "R4 stored word via 40h");
        wr(6, 16'h0010, 1'b1); wr(6, 16'hABCD, 1'b1);
        wait_ready("R4 write completes");
        wr(0, 16'h00FF);
        chk(6, 16'hABCD, "R12 data from last clock with both strobes low (10h setup)");

        // R3 erase block 1
        wr(4, 16'h0020); wr(5, 16'h00D0);
        wait_ready("R3 erase completes");
        wr(0, 16'h00FF);
        chk(5, 16'hFFFF, "R3 erased word");
        chk(6, 16'hFFFF, "R3 erased word");

        // R2 identifier codes
        wr(0, 16'h0090);
        chk(0, 16'h0051, "R2 manufacturer code");
        chk(1, 16'h00A7, "R2 device code");
        chk(6, 16'h0000, "R2 block lock clear");
        chk(3, 16'h0000, "R2 permanent lock clear");

        // R11 sequence error
        wr(0, 16'h0020); wr(0, 16'h0077);
        chk(5, 16'hFFFF, "R11 back in array mode");
        wr(0, 16'h0070);
        chk(0, 16'h00B0, "R11 both error bits set");
        wr(0, 16'h0050);
        chk(0, 16'h0080, "R2 clear keeps status mode");

        // R8 and R9 block lock
        wr(8, 16'h0060); wr(8, 16'h0001);
        wait_ready("R8 lock set completes");
        wr(0, 16'h0090);
        chk(10, 16'h0001, "R8 block 2 locked");
        wr(9, 16'h0040); wr(9, 16'h2222);
        chk(0, 16'h0092, "R9 write to locked block refused");
        wr(0, 16'h0050); wr(0, 16'h00FF);
        chk(9, 16'hFFFF, "R9 locked word unchanged");
        wr(8, 16'h0020); wr(8, 16'h00D0);
        chk(0, 16'h00A2, "R9 erase of locked block refused");
        wr(0, 16'h0050);
        lock_grant = 1'b1;
        wr(9, 16'h0040); wr(9, 16'h2222);
        wait_ready("R9 granted write completes");
        wr(0, 16'h00FF);
        chk(9, 16'h2222, "R9 granted write to locked block");
        wr(0, 16'h0060); wr(0, 16'h00D0);
        wait_ready("R8 clear completes");
        wr(0, 16'h0090);
        chk(10, 16'h0000, "R8 clear all block locks");
        lock_grant = 1'b0;

        // R10 low supply
        vpp_low = 1'b1;
        wr(2, 16'h0040); wr(2, 16'h3333);
        chk(0, 16'h0098, "R10 low supply refusal");
        vpp_low = 1'b0;
        wr(0, 16'h0050); wr(0, 16'h00FF);
        chk(2, 16'hFFFF, "R10 word unchanged");

        // R7 erase suspend
        wr(1, 16'h0040); wr(1, 16'h5555);
        wait_ready("R7 setup write");
        wr(0, 16'h0020); wr(0, 16'h00D0);
        repeat (5) @(negedge clk);
        wr(0, 16'h00B0);
        chk(0, 16'h00C0, "R7 erase suspended status");
        wr(0, 16'h00FF);
        chk(1, 16'h5555, "R7 array read during erase suspend");
        wr(12, 16'h0040); wr(12, 16'h0F0F);
        wait_ready("R7 write during erase suspend");
        chk(0, 16'h00C0, "R7 still suspended after write");
        wr(2, 16'h0040); wr(2, 16'h7777);
        chk(0, 16'h00D0, "R7 write to suspended block refused");
        wr(0, 16'h0050);
        wr(0, 16'h00D0);
        chk(0, 16'h0000, "R7 erase resumed", 16'h0080);
        wait_ready("R7 resumed erase completes");
        chk(0, 16'h0080, "R7 status after resumed erase");
        wr(0, 16'h00FF);
        chk(1, 16'hFFFF, "R7 erase finished after resume");
        chk(2, 16'hFFFF, "R7 refused word not stored");
        chk(12, 16'h0F0F, "R7 word written during suspend");

        // R6 write suspend
        wr(13, 16'h0040); wr(13, 16'h1111);
        wr(0, 16'h00B0);
        chk(0, 16'h0084, "R6 write suspended status");
        wr(12, 16'h0020);
        wr(0, 16'h0070);
        chk(0, 16'h0084, "R6 erase setup ignored while write suspended");
        wr(0, 16'h00FF);
        chk(13, 16'hFFFF, "R6 word not yet written");
        wr(0, 16'h00D0);
        wait_ready("R6 resumed write completes");
        wr(0, 16'h00FF);
        chk(13, 16'h1111, "R6 word written after resume");

        // R8 permanent lock
        wr(12, 16'h0060); wr(12, 16'h0001);
        wait_ready("R8 lock block 3");
        wr(0, 16'h0060); wr(0, 16'h00F1);
        chk(0, 16'h0092, "R8 permanent lock refused without grant");
        wr(0, 16'h0050);
        lock_grant = 1'b1;
        wr(0, 16'h0060); wr(0, 16'h00F1);
        wait_ready("R8 permanent lock completes");
        wr(0, 16'h0090);
        chk(3, 16'h0001, "R8 permanent lock set");
        wr(0, 16'h0060); wr(0, 16'h00D0);
        chk(0, 16'h00A2, "R8 clear refused under permanent lock");
        wr(0, 16'h0050); wr(0, 16'h0090);
        chk(14, 16'h0001, "R8 block 3 lock kept");
        wr(13, 16'h0040); wr(13, 16'h4444);
        chk(0, 16'h0092, "R9 locked block write refused under permanent lock");
        wr(0, 16'h0050);
        wr(4, 16'h0060); wr(4, 16'h0001);
        chk(0, 16'h0092, "R8 block lock refused under permanent lock");
        wr(0, 16'h00FF);
        chk(13, 16'h1111, "R9 protected word unchanged");

        done = 1'b1;
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule